// File: doc/BRIEF.md
# Cascadable Pipelined Sum Output Stage

This block is the last stage of a filter datapath. It receives the sum produced by an adder tree, holds it for a selectable number of clock cycles, and can force it to zero or replace it with its negation. The zero and negate controls go through the same delay as the sum, so each one acts on the sum it was issued with. The conditioned sum then goes into a final adder. That adder's second input is either the block's own registered output, which makes the stage accumulate, or a registered copy of a cascade input.

Up to three instances can be chained: one stage's cascade output feeds the next stage's cascade input, so partial sums add up along the chain. With a single instance, the cascade input can instead add a stored constant, such as a DC offset or a sync/burst pattern, to the filter result. For example, three consecutive outputs can be sum1, then sum1+sum2 (feedback selected), then 003h+sum3 (cascade input selected).

Top module: `cascade_sum_stage`

## Requirements
- R1: A synchronous active-high reset clears the output register, the cascade input register and every stage of the sum/control delay line to zero. The output reads 0 on the cycle after reset.
- R2: With a delay setting of 0, a filter sum sampled at clock edge k reaches the output at edge k+1. The sum is taken at k+1 only when cascade selected with a zero cascade operand.
- R3: With a delay setting d (0 to 7), a sum sampled at edge k enters the final adder at edge k+1+d.
- R4: The zero and negate controls sampled with a sum are delayed by the same d and act on that same sum.
- R5: When the delayed zero control is 1, the conditioned sum is 0.
- R6: When the delayed negate control is 1 and zero is 0, the conditioned sum is the two's-complement negation of the delayed sum.
- R7: When zero and negate are both 1, zero wins and the conditioned sum is 0.
- R8: With the feedback select at 1 during an edge, the new output is the previous output plus the conditioned sum.
- R9: With the feedback select at 0 during an edge, the new output is the conditioned sum plus the cascade input value sampled one edge earlier.
- R10: All addition and negation wraps modulo 2^20, with no saturation.
- R11: The feedback select is not delayed. It takes effect at the edge where it is sampled, whatever the delay setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| filterSum | input | 20 | Sum from the adder tree |
| cascadeIn | input | 20 | Cascade input from a previous stage or a pattern store |
| fbSel | input | 1 | 1: add own output; 0: add registered cascade input |
| zeroCtl | input | 1 | Force the accompanying sum to zero |
| negCtl | input | 1 | Negate the accompanying sum |
| delaySel | input | 3 | Extra delay in cycles, 0 to 7 |
| cascadeOut | output | 20 | Registered result, cascade output |

## Verification
Each result has its own latency, which the bench counts from the edge where the input was sampled:
- A filter sum and its zero/negate flags reach the output d+1 edges later.
- A cascade input value reaches the output one edge after it is registered, so it is used at its second edge.
- The feedback select acts at the very edge where it is sampled.

The bench drives all inputs on the falling clock edge. At every rising edge it advances a reference model that keeps its own delay history. It compares the output on the following falling edge, so every cycle is checked with exactly this alignment.

// File: rtl/cascade_sum_pkg.sv
package cascade_sum_pkg;
  parameter int SUM_W     = 20;
  parameter int MAX_DELAY = 7;
  parameter int DLY_W     = $clog2(MAX_DELAY + 1);

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic             zeroNow;
    logic             negNow;
    logic             useFeedback;
    logic [DLY_W-1:0] tapSel;
  } stage_ctrl_t;
endpackage

// File: rtl/cascade_sum_ctrl.sv
module cascade_sum_ctrl
  import cascade_sum_pkg::*;
#(
  parameter int MAX_DLY = MAX_DELAY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zeroCtl,
  input  logic             negCtl,
  input  logic             fbSel,
  input  logic [DLY_W-1:0] delaySel,
  output stage_ctrl_t      ctrl
);
  localparam int LINE_N = MAX_DLY + 1;

  logic [LINE_N-1:0] zeroLine;
  logic [LINE_N-1:0] negLine;
  logic [DLY_W-1:0]  tapSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      zeroLine[0] <= 1'b0;
      negLine[0]  <= 1'b0;
    end else begin
      zeroLine[0] <= zeroCtl;
      negLine[0]  <= negCtl;
    end
  end

  for (genvar gi = 1; gi < LINE_N; gi++) begin : g_flagLine
    always_ff @(posedge clk) begin
      if (rst) begin
        zeroLine[gi] <= 1'b0;
        negLine[gi]  <= 1'b0;
      end else begin
        zeroLine[gi] <= zeroLine[gi-1];
        negLine[gi]  <= negLine[gi-1];
      end
    end
  end

  always_comb begin
    tapSel = (int'(delaySel) > MAX_DLY) ? DLY_W'(MAX_DLY) : delaySel;
    ctrl.tapSel      = tapSel;
    ctrl.zeroNow     = zeroLine[tapSel];
    ctrl.negNow      = negLine[tapSel];
    ctrl.useFeedback = fbSel;
  end
endmodule

// File: rtl/cascade_sum_dp.sv
module cascade_sum_dp
  import cascade_sum_pkg::*;
#(
  parameter int WIDTH   = SUM_W,
  parameter int MAX_DLY = MAX_DELAY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] filterSum,
  input  logic [WIDTH-1:0] cascadeIn,
  input  stage_ctrl_t      ctrl,
  output logic [WIDTH-1:0] sumOut
);
  localparam int LINE_N = MAX_DLY + 1;

  logic [WIDTH-1:0] sumLine [LINE_N];
  logic [WIDTH-1:0] cascReg;
  logic [WIDTH-1:0] tapSum;
  logic [WIDTH-1:0] condSum;
  logic [WIDTH-1:0] operand;

  always_ff @(posedge clk) begin
    if (rst) begin
      sumLine[0] <= '0;
      cascReg    <= '0;
    end else begin
      sumLine[0] <= filterSum;
      cascReg    <= cascadeIn;
    end
  end

  for (genvar gi = 1; gi < LINE_N; gi++) begin : g_sumLine
    always_ff @(posedge clk) begin
      if (rst) sumLine[gi] <= '0;
      else     sumLine[gi] <= sumLine[gi-1];
    end
  end

  always_comb begin
    tapSum = sumLine[ctrl.tapSel];
    if (ctrl.zeroNow)     condSum = '0;
    else if (ctrl.negNow) condSum = WIDTH'(~tapSum + 1'b1);
    else                  condSum = tapSum;
    operand = ctrl.useFeedback ? sumOut : cascReg;
  end

  always_ff @(posedge clk) begin
    if (rst) sumOut <= '0;
    else     sumOut <= WIDTH'(condSum + operand);
  end
endmodule

// File: rtl/cascade_sum_stage.sv
module cascade_sum_stage
  import cascade_sum_pkg::*;
#(
  parameter int WIDTH   = SUM_W,
  parameter int MAX_DLY = MAX_DELAY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] filterSum,
  input  logic [WIDTH-1:0] cascadeIn,
  input  logic             fbSel,
  input  logic             zeroCtl,
  input  logic             negCtl,
  input  logic [DLY_W-1:0] delaySel,
  output logic [WIDTH-1:0] cascadeOut
);
  stage_ctrl_t ctrlBus;

  cascade_sum_ctrl #(.MAX_DLY(MAX_DLY)) ctrl_i (
    .clk(clk), .rst(rst), .zeroCtl(zeroCtl), .negCtl(negCtl),
    .fbSel(fbSel), .delaySel(delaySel), .ctrl(ctrlBus)
  );

  cascade_sum_dp #(.WIDTH(WIDTH), .MAX_DLY(MAX_DLY)) dp_i (
    .clk(clk), .rst(rst), .filterSum(filterSum), .cascadeIn(cascadeIn),
    .ctrl(ctrlBus), .sumOut(cascadeOut)
  );
endmodule

// File: rtl/cascade_sum_stage_chk.sv
module cascade_sum_stage_chk
  import cascade_sum_pkg::*;
#(
  parameter int WIDTH = SUM_W
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] cascadeIn,
  input logic             fbSel,
  input logic             zeroCtl,
  input logic [DLY_W-1:0] delaySel,
  input logic [WIDTH-1:0] cascadeOut,
  input stage_ctrl_t      ctrlBus
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> cascadeOut == '0);

  a_r4_zero_align: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && delaySel == '0) |-> ctrlBus.zeroNow == $past(zeroCtl));

  a_r7_zero_wins: assert property (@(posedge clk) disable iff (rst)
    (ctrlBus.zeroNow && ctrlBus.negNow && ctrlBus.useFeedback)
      |=> cascadeOut == $past(cascadeOut));

  a_r8_hold_on_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrlBus.zeroNow && fbSel) |=> cascadeOut == $past(cascadeOut));

  a_r9_cascade_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ctrlBus.zeroNow && !fbSel)
      |=> cascadeOut == $past(cascadeIn, 2));
endmodule

bind cascade_sum_stage cascade_sum_stage_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .cascadeIn(cascadeIn), .fbSel(fbSel),
  .zeroCtl(zeroCtl), .delaySel(delaySel), .cascadeOut(cascadeOut),
  .ctrlBus(ctrlBus)
);

// File: tb/cascade_sum_stage_tb.sv
`timescale 1ns/1ps
module cascade_sum_stage_tb_top;
  localparam int W = 20;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] filterSum = '0;
  logic [W-1:0] cascadeIn = '0;
  logic         fbSel = 1'b0;
  logic         zeroCtl = 1'b0;
  logic         negCtl = 1'b0;
  logic [2:0]   delaySel = '0;
  logic [W-1:0] cascadeOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cascade_sum_stage dut_i (
    .clk(clk), .rst(rst), .filterSum(filterSum), .cascadeIn(cascadeIn),
    .fbSel(fbSel), .zeroCtl(zeroCtl), .negCtl(negCtl),
    .delaySel(delaySel), .cascadeOut(cascadeOut)
  );

  // reference model state
  logic [W-1:0] mSum [8];
  logic         mZero [8];
  logic         mNeg [8];
  logic [W-1:0] mCasc;
  logic [W-1:0] mOut;

  function automatic logic [W-1:0] condition(logic [W-1:0] s, logic z, logic n);
    if (z) return '0;
    if (n) return (0 - s) & MASK;
    return s;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      mSum[i] = '0; mZero[i] = 0; mNeg[i] = 0;
    end
    mCasc = '0; mOut = '0;
  endtask

  task automatic check(string tag, logic [W-1:0] exp);
    nChecks++;
    if (cascadeOut !== exp) begin
      nFails++;
      $display("FAIL %s: cascadeOut=%05h expected=%05h", tag, cascadeOut, exp);
    end
  endtask

  // called at a falling edge: drive, clock, update model, compare
  task automatic step(logic [W-1:0] s, logic [W-1:0] c, logic fb,
                      logic z, logic n, logic [2:0] d, string tag);
    logic [W-1:0] opnd;
    filterSum = s; cascadeIn = c; fbSel = fb;
    zeroCtl = z; negCtl = n; delaySel = d;
    @(posedge clk);
    opnd = fb ? mOut : mCasc;
    mOut = (condition(mSum[d], mZero[d], mNeg[d]) + opnd) & MASK;
    for (int i = 7; i > 0; i--) begin
      mSum[i] = mSum[i-1]; mZero[i] = mZero[i-1]; mNeg[i] = mNeg[i-1];
    end
    mSum[0] = s; mZero[0] = z; mNeg[0] = n; mCasc = c;
    @(negedge clk);
    check(tag, mOut);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    // R1: reset clears output and delay line
    filterSum = 20'hABCDE; cascadeIn = 20'h12345;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", '0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) step('0, '0, 1'b0, 1'b0, 1'b0, 3'd7, "R1");

    // R2/R9/R8: example sequence sum1, sum1+sum2, 003h+sum3
    step(20'h00011, '0, 0, 0, 0, 3'd0, "R2");
    step(20'h00022, '0, 0, 0, 0, 3'd0, "R2");
    step(20'h00033, 20'h00003, 1, 0, 0, 3'd0, "R8");
    step('0, '0, 0, 0, 0, 3'd0, "R9");
    step('0, '0, 0, 0, 0, 3'd0, "R9");

    // R3: impulse latency at each delay
    for (int d = 0; d < 8; d++) begin
      step(20'h00100 + 20'(d), '0, 0, 0, 0, 3'(d), "R3");
      for (int k = 0; k < 9; k++) step('0, '0, 0, 0, 0, 3'(d), "R3");
    end

    // R4/R5/R6/R7 with delay 3
    step(20'h00050, '0, 0, 1, 0, 3'd3, "R5");
    step(20'h00050, '0, 0, 0, 1, 3'd3, "R6");
    step(20'h00050, '0, 0, 1, 1, 3'd3, "R7");
    for (int k = 0; k < 6; k++) step(20'h00007, '0, 0, 0, 0, 3'd3, "R4");

    // R10: wrap on accumulation and negation of most negative
    step(20'h80000, '0, 0, 0, 0, 3'd0, "R10");
    step(20'h80000, '0, 1, 0, 1, 3'd0, "R10");
    step(20'hFFFFF, 20'h00001, 1, 0, 0, 3'd0, "R10");
    step('0, 20'hFFFFF, 0, 0, 0, 3'd0, "R10");
    step('0, '0, 0, 0, 0, 3'd0, "R10");

    // R11: feedback select acts immediately at long delay
    for (int k = 0; k < 6; k++) step(20'h00010, 20'h00100, k[0], 0, 0, 3'd6, "R11");

    // random mix
    for (int k = 0; k < 3000; k++)
      step(20'($urandom), 20'($urandom), 1'($urandom), ($urandom % 5) == 0,
           ($urandom % 4) == 0, 3'($urandom), "R8");

    // R1: mid-stream reset
    rst = 1'b1;
    @(posedge clk); model_reset(); @(negedge clk);
    check("R1", '0);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) step('0, '0, 1, 0, 0, 3'd7, "R1");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule